// File: doc/BRIEF.md
# I2C SCL Bit-Timing Generator

This block times the SCL clock of an I2C master. A fast system clock is first divided by a programmable factor of 1 to 8 into an internal clock enable. Whole SCL periods are then counted out in internal clocks. Each period lasts an affine function of a 6-bit cycle field: a fixed base of 20, plus 8 per field step, plus a fixed allowance `F_ALLOW` that covers line fall time, rise time and internal delay. The allowance is a parameter because controller instances differ in their internal delay.

Each period is a low phase followed by a high phase. The low phase is the lower half of the period, rounded down. The high phase is the rest. The block drives `scl_low` as the open-drain pull-down. It pulses `tick_low` when a low phase starts and `tick_high` when a high phase starts, so that a byte engine can change SDA while SCL is low and sample SDA while it is high.

During the high phase the sensed line `scl_in` is watched. While a target holds SCL low, the high-phase count waits. `scl_in` is expected to come already synchronised to `clk`. A new control word takes effect only when the next period starts. While `enable` is low, the counters are held and SCL is released.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and at any time while `enable` is low, `scl_low` is 0 (SCL released) and neither tick pulses.
- R2: In `clk_ctrl`, bits 2:0 hold the division field DIV and bits 8:3 hold the cycle field CYC (0 to 63).
- R3: The internal clock enable recurs every D = DIV+1 clock cycles, so D ranges from 1 to 8.
- R4: With no stretching, successive `tick_low` pulses are exactly (20 + 8*CYC + F_ALLOW) * D clock cycles apart.
- R5: The low phase lasts floor(P/2) internal clocks and the high phase lasts P - floor(P/2), where P = 20 + 8*CYC + F_ALLOW. `tick_high` marks the end of the low phase. `scl_low` is 1 exactly from a `tick_low` cycle up to the following `tick_high` cycle, and the two ticks never coincide.
- R6: In the high phase, every internal clock on which `scl_in` reads 0 is not counted. The high phase therefore lasts longer by that many internal clocks, and no `tick_low` occurs while SCL is held low.
- R7: A change of `clk_ctrl` while the generator runs does not alter the period in progress. It applies from the next `tick_low` onward.
- R8: Dropping `enable` releases SCL and stops the ticks from the next clock cycle on, even in mid-period.
- R9: After `enable` rises, the first `tick_low` is seen D clock cycles later, and SCL goes low with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low holds counters and releases SCL |
| clk_ctrl | input | 9 | Control word: DIV in bits 2:0, CYC in bits 8:3 |
| scl_in | input | 1 | Sensed SCL level, synchronous to clk |
| scl_low | output | 1 | 1 = pull SCL low, 0 = release |
| tick_low | output | 1 | One-cycle pulse as a low phase begins |
| tick_high | output | 1 | One-cycle pulse as a high phase begins |

## Verification
The hardest situation to reach from the ports is a control word that changes inside a running period, because it must not disturb that period. The bench waits for a `tick_low` and rewrites `clk_ctrl` on the next falling edge. It then measures the period in progress and the one after it. This is done twice, once changing only the cycle field and once changing only the division field. Clock stretching is reached the same way. The bench models the open-drain line and, on the `tick_high` cycle, holds it low for a known number of cycles, then measures how long the high phase lasted.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
    parameter int DIV_W = 3;
    parameter int CYC_W = 6;
    localparam int CTRL_W = DIV_W + CYC_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [DIV_W-1:0] div;
    } tg_cfg_t;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             ce
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        ce    = run && (cnt_q >= div);
        cnt_d = (!run || ce) ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && div != '0) |=> (!ce || div == '0)); // R3
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
    import scl_tg_pkg::*;
#(
    parameter int F_ALLOW = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enable,
    input  logic    ce,
    input  logic    scl_in,
    input  tg_cfg_t cfg_in,
    output tg_cfg_t cfg_act,
    output logic    scl_low,
    output logic    tick_low,
    output logic    tick_high
);
    localparam int MAX_PER = 20 + 8 * ((1 << CYC_W) - 1) + F_ALLOW;
    localparam int PER_W   = $clog2(MAX_PER + 1);

    typedef struct packed {
        phase_e           ph;
        logic [PER_W-1:0] cnt;
        tg_cfg_t          cfg;
        logic             scl_low;
        logic             tk_lo;
        logic             tk_hi;
    } st_t;

    st_t st_d, st_q;
    logic [PER_W-1:0] per, lo_len, hi_len;

    always_comb begin
        per    = PER_W'(20) + (PER_W'(st_q.cfg.cyc) << 3) + PER_W'(F_ALLOW);
        lo_len = per >> 1;
        hi_len = per - lo_len;

        st_d       = st_q;
        st_d.tk_lo = 1'b0;
        st_d.tk_hi = 1'b0;

        if (!enable) begin
            st_d.ph      = PH_IDLE;
            st_d.cnt     = '0;
            st_d.scl_low = 1'b0;
            st_d.cfg     = cfg_in;
        end else begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    st_d.cfg = cfg_in;
                    if (ce) begin
                        st_d.ph      = PH_LOW;
                        st_d.cnt     = '0;
                        st_d.scl_low = 1'b1;
                        st_d.tk_lo   = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (ce) begin
                        if (st_q.cnt == lo_len - PER_W'(1)) begin
                            st_d.ph      = PH_HIGH;
                            st_d.cnt     = '0;
                            st_d.scl_low = 1'b0;
                            st_d.tk_hi   = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + PER_W'(1);
                        end
                    end
                end
                PH_HIGH: begin
                    if (ce && scl_in) begin
                        if (st_q.cnt == hi_len - PER_W'(1)) begin
                            st_d.ph      = PH_LOW;
                            st_d.cnt     = '0;
                            st_d.scl_low = 1'b1;
                            st_d.tk_lo   = 1'b1;
                            st_d.cfg     = cfg_in;
                        end else begin
                            st_d.cnt = st_q.cnt + PER_W'(1);
                        end
                    end
                end
                default: begin
                    st_d.ph      = PH_IDLE;
                    st_d.cnt     = '0;
                    st_d.scl_low = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph      <= PH_IDLE;
            st_q.cnt     <= '0;
            st_q.cfg     <= '0;
            st_q.scl_low <= 1'b0;
            st_q.tk_lo   <= 1'b0;
            st_q.tk_hi   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_act   = st_q.cfg;
    assign scl_low   = st_q.scl_low;
    assign tick_low  = st_q.tk_lo;
    assign tick_high = st_q.tk_hi;

    AST_TICK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_low && tick_high)); // R5
    AST_HI_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_high |-> !scl_low); // R5
    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st_q.ph == PH_HIGH && !scl_in) |=> (st_q.ph == PH_HIGH && $stable(st_q.cnt))); // R6
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st_q.ph != PH_IDLE) |=> (tick_low || $stable(cfg_act))); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_low && !tick_low && !tick_high)); // R8
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tg_pkg::*;
#(
    parameter int F_ALLOW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CTRL_W-1:0] clk_ctrl,
    input  logic              scl_in,
    output logic              scl_low,
    output logic              tick_low,
    output logic              tick_high
);
    tg_cfg_t cfg_in, cfg_act;
    logic    ce;

    assign cfg_in = tg_cfg_t'(clk_ctrl);

    scl_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .div   (cfg_act.div),
        .ce    (ce)
    );

    scl_phase_ctr #(.F_ALLOW(F_ALLOW)) u_ph (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .ce        (ce),
        .scl_in    (scl_in),
        .cfg_in    (cfg_in),
        .cfg_act   (cfg_act),
        .scl_low   (scl_low),
        .tick_low  (tick_low),
        .tick_high (tick_high)
    );
endmodule

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;
    localparam int F = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [8:0] clk_ctrl = '0;
    logic       stretch = 1'b0;
    logic       scl_in, scl_low, tick_low, tick_high;
    int total = 0;
    int bad = 0;

    assign scl_in = !scl_low && !stretch;

    always #5 clk = ~clk;

    scl_timing_gen #(.F_ALLOW(F)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_ctrl(clk_ctrl),
        .scl_in(scl_in), .scl_low(scl_low), .tick_low(tick_low), .tick_high(tick_high)
    );

    function automatic int per_of(input int cyc);
        return 20 + 8 * cyc + F;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_lo(input int maxc, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick_low && n < maxc);
    endtask

    task automatic wait_hi(input int maxc, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick_high && n < maxc);
    endtask

    task automatic t_reset_idle();
        int ticks = 0, lows = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            ticks += int'(tick_low) + int'(tick_high);
            lows  += int'(scl_low);
        end
        chk("R1 ticks while idle", ticks, 0);
        chk("R1 scl pulled while idle", lows, 0);
    endtask

    task automatic t_period(input int dv, input int cyc);
        int n, d, p;
        d = dv + 1;
        p = per_of(cyc);
        enable = 1'b0;
        clk_ctrl = 9'((cyc << 3) | dv);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        wait_lo(20, n);
        chk("R9 first tick delay", n, d);
        chk("R9 scl low at start", int'(scl_low), 1);
        wait_hi(p * d + 10, n);
        chk("R5 R2 low phase clocks", n, (p / 2) * d);
        chk("R5 scl released at tick_high", int'(scl_low), 0);
        wait_lo(p * d + 10, n);
        chk("R5 high phase clocks", n, (p - p / 2) * d);
        wait_lo(p * d + 10, n);
        chk("R4 R3 full period clocks", n, p * d);
        enable = 1'b0;
    endtask

    task automatic t_stretch();
        int n, hold;
        hold = 40;
        enable = 1'b0;
        clk_ctrl = 9'h000;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        wait_hi(200, n);
        stretch = 1'b1;
        n = 0;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            n += int'(tick_low);
        end
        chk("R6 no tick_low while held", n, 0);
        stretch = 1'b0;
        wait_lo(200, n);
        chk("R6 stretched high phase", n + hold, (per_of(0) - per_of(0) / 2) + hold);
        enable = 1'b0;
    endtask

    task automatic t_cfg_change(input int dv2, input int cyc2);
        int n;
        enable = 1'b0;
        clk_ctrl = 9'h000;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        wait_lo(50, n);
        clk_ctrl = 9'((cyc2 << 3) | dv2);
        wait_lo(5000, n);
        chk("R7 period in progress kept", n, per_of(0));
        wait_lo(5000, n);
        chk("R7 new word applied next", n, per_of(cyc2) * (dv2 + 1));
        enable = 1'b0;
    endtask

    task automatic t_disable_mid();
        int n, ticks = 0, lows = 0;
        enable = 1'b0;
        clk_ctrl = 9'h00A;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        wait_lo(50, n);
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R8 released next cycle", int'(scl_low), 0);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            ticks += int'(tick_low) + int'(tick_high);
            lows  += int'(scl_low);
        end
        chk("R8 ticks after disable", ticks, 0);
        chk("R8 scl pulled after disable", lows, 0);
        enable = 1'b1;
        wait_lo(50, n);
        chk("R9 restart delay", n, 3);
        enable = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset scl", int'(scl_low), 0);
        rst_n = 1'b1;
        t_reset_idle();
        t_period(0, 0);
        t_period(1, 2);
        t_period(7, 5);
        t_period(3, 63);
        t_stretch();
        t_cfg_change(0, 1);
        t_cfg_change(1, 0);
        t_disable_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule